// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between one core's memory request port and a shared memory. Stores are held in a small circular queue and leave for memory one at a time, in the order they arrived. Loads look in the queue first and take the data of the youngest queued store to the same address. A load that finds no match reads shared memory, and it may finish before older queued stores to other addresses have been written.

The core issues one request at a time on a valid/ready channel. The operation code selects a load, a store, a full fence, a store-only fence or a locked add. Load and locked-add results come back as a one-cycle response pulse. A locked add asks for the global lock and waits for the grant. It then reads the old value, with forwarding, and queues old plus operand as a store. It drains the whole queue, returns the old value and drops the lock request. While another thread holds the lock, the block issues no memory writes and no memory reads.

Top module: `tso_store_buffer`

## Requirements
- R1: Queued stores reach the memory write port in exactly the order they were accepted, including stores to different addresses.
- R2: A load (op code 0) whose address matches queued stores returns the data of the most recently accepted matching store, as a response pulse one cycle after the load is accepted, without a memory read.
- R3: A load with no matching entry is served from the memory read port, and its response may be delivered while older queued stores to other addresses are still waiting to drain.
- R4: A full fence (op code 2) is not accepted until the queue is empty, so no later request is accepted before every earlier store has been written.
- R5: A locked add (op code 4) raises lock_req_o and does not read until lock_gnt_i is high. It queues old value plus the write-data operand as a store, returns the old value, and drops lock_req_o only after every queued store has been written.
- R6: While other_locked_i is high and this block holds no lock request, mem_wr_valid_o and mem_rd_valid_o stay low.
- R7: A store-only fence (op code 3) is accepted in the cycle it is presented, even with stores queued, and later loads proceed without waiting for the drain.
- R8: When the queue holds DEPTH entries, a store (op code 1) sees req_ready_o low until an entry has drained.
- R9: At most one entry drains per cycle, and the queue head advances only in a cycle where mem_wr_valid_o and mem_wr_ready_i are both high, so no store is lost or repeated when the memory stalls.
- R10: After reset the queue is empty, no response, write or read is pending, lock_req_o is low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_op_i | input | 3 | 0 load, 1 store, 2 full fence, 3 store fence, 4 locked add |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Store data or locked-add operand |
| rsp_valid_o | output | 1 | One-cycle pulse with load or locked-add result |
| rsp_data_o | output | DATA_W | Load data or old value of locked add |
| mem_wr_valid_o | output | 1 | Drain write valid |
| mem_wr_ready_i | input | 1 | Memory accepts the write |
| mem_wr_addr_o | output | ADDR_W | Drain write address |
| mem_wr_data_o | output | DATA_W | Drain write data |
| mem_rd_valid_o | output | 1 | Memory read request valid |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_rvalid_i | input | 1 | Read data valid |
| mem_rd_rdata_i | input | DATA_W | Read data |
| lock_req_o | output | 1 | Global lock request |
| lock_gnt_i | input | 1 | Global lock granted |
| other_locked_i | input | 1 | Another thread holds the global lock |

## Verification
A wrong head or tail pointer appears within one drain beat as a write whose address or data differs from the accepted store order. It can also appear as a forwarded load that returns an older store's data. A wrong occupancy count shows up at req_ready_o on the next store or fence, which the queue then accepts too early or holds off for good. A control path that drops the lock request early, or that ignores the other-thread lock, becomes visible at the memory ports in the same cycle.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_FENCE  = 3'd2,
    OP_SFENCE = 3'd3,
    OP_LKADD  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_LK_ACQ,
    S_LK_PUSH,
    S_LK_DRAIN
  } state_e;
endpackage

// File: rtl/tso_sb_queue.sv
module tso_sb_queue #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic [ADDR_W-1:0]             push_addr_i,
  input  logic [DATA_W-1:0]             push_data_i,
  input  logic                          pop_i,
  output logic                          full_o,
  output logic                          empty_o,
  output logic [CNT_W-1:0]              count_o,
  output logic [PTR_W-1:0]              head_o,
  output logic [PTR_W-1:0]              tail_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  ent_data_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_addr_o[i] <= '0;
        ent_data_o[i] <= '0;
      end else if (push_i && tail_q == PTR_W'(i)) begin
        ent_addr_o[i] <= push_addr_i;
        ent_data_o[i] <= push_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      if (pop_i)  head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      if (push_i && !pop_i)      count_q <= count_q + 1'b1;
      else if (pop_i && !push_i) count_q <= count_q - 1'b1;
    end
  end

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign count_o = count_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;
endmodule

// File: rtl/tso_sb_fwd.sv
module tso_sb_fwd #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data_i,
  input  logic [PTR_W-1:0]             tail_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            data_o
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (ent_addr_i[i] == addr_i);
  end

  // youngest first: walk back from tail-1 over live entries
  always_comb begin
    logic [PTR_W-1:0] idx;
    hit_o  = 1'b0;
    data_o = '0;
    idx    = tail_i;
    for (int k = 0; k < DEPTH; k++) begin
      idx = (idx == '0) ? PTR_W'(DEPTH - 1) : idx - 1'b1;
      if (!hit_o && (CNT_W'(k) < count_i) && match[idx]) begin
        hit_o  = 1'b1;
        data_o = ent_data_i[idx];
      end
    end
  end
endmodule

// File: rtl/tso_sb_ctrl.sv
module tso_sb_ctrl
  import tso_sb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic              fwd_hit_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  output logic [ADDR_W-1:0] fwd_addr_o,
  input  logic              full_i,
  input  logic              empty_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [DATA_W-1:0] push_data_o,
  input  logic              other_locked_i,
  input  logic              lock_gnt_i,
  output logic              lock_req_o,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_rvalid_i,
  input  logic [DATA_W-1:0] mem_rd_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  state_e            state_q;
  op_e               op;
  logic              lock_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, old_q;

  assign op = op_e'(req_op_i);

  always_comb begin
    req_ready_o = 1'b0;
    push_o      = 1'b0;
    push_addr_o = req_addr_i;
    push_data_o = req_wdata_i;
    if (state_q == S_IDLE) begin
      unique case (op)
        OP_STORE: begin
          req_ready_o = !full_i;
          push_o      = req_valid_i && !full_i;
        end
        OP_FENCE: req_ready_o = empty_i;
        default:  req_ready_o = 1'b1;
      endcase
    end else if (state_q == S_LK_PUSH) begin
      push_o      = !full_i;
      push_addr_o = addr_q;
      push_data_o = old_q + opnd_q;
    end
  end

  assign fwd_addr_o     = (state_q == S_IDLE) ? req_addr_i : addr_q;
  assign mem_rd_valid_o = (state_q == S_RD_REQ) && (lock_q || !other_locked_i);
  assign mem_rd_addr_o  = addr_q;
  assign lock_req_o     = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      lock_q      <= 1'b0;
      addr_q      <= '0;
      opnd_q      <= '0;
      old_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i && req_ready_o) begin
          if (op == OP_LOAD) begin
            if (fwd_hit_i) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= fwd_data_i;
            end else begin
              addr_q  <= req_addr_i;
              state_q <= S_RD_REQ;
            end
          end else if (op == OP_LKADD) begin
            addr_q  <= req_addr_i;
            opnd_q  <= req_wdata_i;
            lock_q  <= 1'b1;
            state_q <= S_LK_ACQ;
          end
        end
        S_LK_ACQ: if (lock_gnt_i) begin
          if (fwd_hit_i) begin
            old_q   <= fwd_data_i;
            state_q <= S_LK_PUSH;
          end else begin
            state_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (mem_rd_valid_o && mem_rd_ready_i) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rd_rvalid_i) begin
          if (lock_q) begin
            old_q   <= mem_rd_rdata_i;
            state_q <= S_LK_PUSH;
          end else begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= mem_rd_rdata_i;
            state_q     <= S_IDLE;
          end
        end
        S_LK_PUSH: if (!full_i) state_q <= S_LK_DRAIN;
        S_LK_DRAIN: if (empty_i) begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= old_q;
          lock_q      <= 1'b0;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_wr_valid_o,
  input  logic              mem_wr_ready_i,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_rvalid_i,
  input  logic [DATA_W-1:0] mem_rd_rdata_i,
  output logic              lock_req_o,
  input  logic              lock_gnt_i,
  input  logic              other_locked_i
);
  logic                         push, pop, full, empty, fwd_hit;
  logic [ADDR_W-1:0]            push_addr, fwd_addr;
  logic [DATA_W-1:0]            push_data, fwd_data;
  logic [CNT_W-1:0]             count;
  logic [PTR_W-1:0]             head, tail;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;

  tso_sb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(push_addr), .push_data_i(push_data),
    .pop_i(pop), .full_o(full), .empty_o(empty), .count_o(count),
    .head_o(head), .tail_o(tail), .ent_addr_o(ent_addr), .ent_data_o(ent_data)
  );

  tso_sb_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
    .ent_addr_i(ent_addr), .ent_data_i(ent_data), .tail_i(tail),
    .count_i(count), .addr_i(fwd_addr), .hit_o(fwd_hit), .data_o(fwd_data)
  );

  tso_sb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .fwd_hit_i(fwd_hit), .fwd_data_i(fwd_data), .fwd_addr_o(fwd_addr),
    .full_i(full), .empty_i(empty),
    .push_o(push), .push_addr_o(push_addr), .push_data_o(push_data),
    .other_locked_i, .lock_gnt_i, .lock_req_o,
    .mem_rd_valid_o, .mem_rd_ready_i, .mem_rd_addr_o,
    .mem_rd_rvalid_i, .mem_rd_rdata_i,
    .rsp_valid_o, .rsp_data_o
  );

  // drain gate: another thread owning the lock freezes the queue
  assign mem_wr_valid_o = !empty && !other_locked_i;
  assign mem_wr_addr_o  = ent_addr[head];
  assign mem_wr_data_o  = ent_data[head];
  assign pop            = mem_wr_valid_o && mem_wr_ready_i;
endmodule

// File: rtl/tso_store_buffer_chk.sv
module tso_store_buffer_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [2:0]       req_op_i,
  input logic             mem_wr_valid_o,
  input logic             mem_wr_ready_i,
  input logic             mem_rd_valid_o,
  input logic             lock_req_o,
  input logic             lock_gnt_i,
  input logic             other_locked_i,
  input logic             buf_empty,
  input logic             buf_full,
  input logic [PTR_W-1:0] head_ptr
);
  a_r4_fence_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i == 3'd2) |-> buf_empty);

  a_r5_unlock_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_req_o) |-> buf_empty);

  a_r5_no_read_before_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_req_o && !lock_gnt_i) |-> !mem_rd_valid_o);

  a_r6_frozen_by_other_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_locked_i && !lock_req_o) |-> (!mem_wr_valid_o && !mem_rd_valid_o));

  a_r8_no_store_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_full && req_valid_i && req_op_i == 3'd1) |-> !req_ready_o);

  a_r9_head_only_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_valid_o && mem_wr_ready_i) |=> $stable(head_ptr));
endmodule

bind tso_store_buffer tso_store_buffer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_op_i(req_op_i),
  .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_ready_i(mem_wr_ready_i),
  .mem_rd_valid_o(mem_rd_valid_o), .lock_req_o(lock_req_o),
  .lock_gnt_i(lock_gnt_i), .other_locked_i(other_locked_i),
  .buf_empty(empty), .buf_full(full), .head_ptr(head)
);

// File: tb/tso_store_buffer_test.sv
`timescale 1ns/1ps
module tso_store_buffer_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, FN = 3'd2, SF = 3'd3, LK = 3'd4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = LD;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid; logic [DW-1:0] rsp_data;
  logic wr_valid, wr_ready = 0; logic [AW-1:0] wr_addr; logic [DW-1:0] wr_data;
  logic rd_valid, rd_pend = 0; logic [AW-1:0] rd_addr; logic [DW-1:0] rd_data = '0;
  logic lock_req, lock_gnt, gnt_allow = 0, other_locked = 0;
  logic toggle_en = 0;

  int compared = 0, mismatched = 0, rsp_seen = 0, wr_seen = 0, wr_issued = 0, cyc = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] exp_rsp [$];
  logic [AW+DW-1:0] exp_wr [$];

  always #10 clk = ~clk;

  assign lock_gnt = lock_req & gnt_allow;

  tso_store_buffer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_wr_valid_o(wr_valid), .mem_wr_ready_i(wr_ready),
    .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .mem_rd_valid_o(rd_valid), .mem_rd_ready_i(1'b1), .mem_rd_addr_o(rd_addr),
    .mem_rd_rvalid_i(rd_pend), .mem_rd_rdata_i(rd_data),
    .lock_req_o(lock_req), .lock_gnt_i(lock_gnt), .other_locked_i(other_locked)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    if (wr_valid && wr_ready) mem[wr_addr[7:0]] <= wr_data;
    if (rd_valid) begin rd_pend <= 1'b1; rd_data <= mem[rd_addr[7:0]]; end
    else rd_pend <= 1'b0;
  end

  // monitors
  logic prev_lock = 0;
  always @(negedge clk) begin
    cyc++;
    if (toggle_en) wr_ready = ~wr_ready;
    if (rst_n && rsp_valid) begin
      rsp_seen++;
      if (exp_rsp.size() == 0) check(0, "R2/R3/R5 unexpected response", 64'(rsp_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_rsp.pop_front();
        check(rsp_data == e, "R2/R3/R5 response data", 64'(rsp_data), 64'(e));
      end
    end
    if (rst_n && wr_valid && wr_ready) begin
      wr_seen++;
      if (exp_wr.size() == 0) check(0, "R1 unexpected write", 64'({wr_addr, wr_data}), 0);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_wr.pop_front();
        check({wr_addr, wr_data} == e, "R1 drain order", 64'({wr_addr, wr_data}), 64'(e));
      end
    end
    if (prev_lock && !lock_req)
      check(wr_seen == wr_issued, "R5 lock dropped before drain", 64'(wr_seen), 64'(wr_issued));
    prev_lock = lock_req;
  end

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    case (op)
      ST: begin shadow[a[7:0]] = d; exp_wr.push_back({a, d}); wr_issued++; end
      LD: exp_rsp.push_back(shadow[a[7:0]]);
      LK: begin
        exp_rsp.push_back(shadow[a[7:0]]);
        shadow[a[7:0]] = shadow[a[7:0]] + d;
        exp_wr.push_back({a, shadow[a[7:0]]}); wr_issued++;
      end
      default: ;
    endcase
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic wait_rsp(input int n);
    while (rsp_seen < n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 32'h1000 + i; shadow[i] = 32'h1000 + i; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready && !wr_valid && !rd_valid && !lock_req && !rsp_valid, "R10 reset outputs",
          64'({req_ready, wr_valid, rd_valid, lock_req, rsp_valid}), 64'b10000);
    rst_n = 1;

    // R2 youngest match forwards, R3 miss completes ahead of drain
    issue(ST, 16'h10, 32'hA1); issue(ST, 16'h20, 32'hB2); issue(ST, 16'h10, 32'hC3);
    issue(LD, 16'h10, 0); wait_rsp(1);
    check(!rd_valid, "R2 no memory read on hit", 64'(rd_valid), 0);
    issue(LD, 16'h30, 0); wait_rsp(2);
    check(wr_valid && wr_seen == 0, "R3 load passed queued stores", 64'(wr_seen), 0);

    // R8 full stall
    issue(ST, 16'h40, 32'hD4);
    @(negedge clk); req_valid = 1; req_op = ST; req_addr = 16'h50; req_wdata = 32'hE5;
    repeat (3) begin
      @(negedge clk);
      check(!req_ready, "R8 store held while full", 64'(req_ready), 0);
    end
    req_valid = 0;
    wr_ready = 1;
    issue(ST, 16'h50, 32'hE5);

    // R9 stalling memory: order and count kept
    toggle_en = 1;
    issue(ST, 16'h60, 32'h11); issue(ST, 16'h61, 32'h22); issue(ST, 16'h60, 32'h33);
    repeat (20) @(negedge clk);
    toggle_en = 0;
    check(wr_seen == wr_issued, "R9 every store written once", 64'(wr_seen), 64'(wr_issued));

    // R4 full fence waits for empty
    wr_ready = 0;
    issue(ST, 16'h70, 32'h44); issue(ST, 16'h71, 32'h55);
    @(negedge clk); req_valid = 1; req_op = FN;
    repeat (3) begin
      @(negedge clk);
      check(!req_ready, "R4 fence held with stores queued", 64'(req_ready), 0);
    end
    req_valid = 0; wr_ready = 1;
    issue(FN, 0, 0);
    check(wr_seen == wr_issued, "R4 fence after drain", 64'(wr_seen), 64'(wr_issued));

    // R7 store fence does not wait
    wr_ready = 0;
    issue(ST, 16'h80, 32'h66);
    @(negedge clk); req_valid = 1; req_op = SF;
    #1 check(req_ready, "R7 store fence accepted at once", 64'(req_ready), 1);
    @(posedge clk); #1 req_valid = 0;
    issue(LD, 16'h90, 0); wait_rsp(3);
    check(wr_valid && wr_seen != wr_issued, "R7 load not blocked", 64'(wr_seen), 64'(wr_issued));
    wr_ready = 1;

    // R6 other thread holds lock
    repeat (3) @(negedge clk);
    other_locked = 1;
    issue(ST, 16'h81, 32'h77); issue(LD, 16'h91, 0);
    repeat (4) begin
      @(negedge clk);
      check(!wr_valid && !rd_valid, "R6 frozen under foreign lock", 64'({wr_valid, rd_valid}), 0);
    end
    other_locked = 0; wait_rsp(4);

    // R5 locked add, forwarded old value
    wr_ready = 0;
    issue(ST, 16'h10, 32'h100);
    issue(LK, 16'h10, 32'h5);
    repeat (3) begin
      @(negedge clk);
      check(lock_req && !rd_valid && rsp_seen == 4, "R5 waits for grant", 64'(lock_req), 1);
    end
    gnt_allow = 1; wr_ready = 1; wait_rsp(5);
    // R5 locked add on memory value
    issue(LK, 16'hA0, 32'h7); wait_rsp(6);
    issue(LD, 16'hA0, 0); wait_rsp(7);
    gnt_allow = 0;

    repeat (10) @(negedge clk);
    check(exp_rsp.size() == 0 && exp_wr.size() == 0, "R1 all expected items seen",
          64'(exp_rsp.size() + exp_wr.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    check(0, "watchdog", 64'(cyc), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule